// File: doc/BRIEF.md
# Bit-Split Multi-Keyword Stream Matcher

This block scans a byte stream, typically a packet payload, for every keyword of one keyword subset at once. Each incoming byte is cut into narrow bit slices, and each slice steps its own small deterministic automaton. The next-state table of an automaton has one pointer for every value its slice can take. Every table entry also carries a partial-match vector with one bit per keyword. A keyword is reported only when all slice automata agree, which means the bit is set in the bitwise AND of the vectors of all their current states.

The tables are built offline, with failure transitions already folded in. They are loaded through a write port while no packet is in flight. The engine then consumes one byte per clock, does one lookup per automaton per byte and never backtracks. It returns a registered match vector one cycle after each byte. A start-of-packet byte sends every automaton back to state 0, so a match never spans two packets. A sticky flag records whether anything matched in the current packet, and it is read alongside the end-of-packet strobe.

Top module: `bitsplit_matcher`

## Requirements
- R1: After reset, out_valid, out_match, out_eop and out_any are all 0, and every automaton is in state 0.
- R2: Automaton i follows bits [i*SLICE_W +: SLICE_W] of in_byte, bit 0 being the least significant. SLICE_W may be 1, 2, 4 or 8, and there are 8/SLICE_W automata; the default SLICE_W=1 gives eight single-bit automata.
- R3: For each byte with in_valid high, every automaton moves to the pointer that its slice value selects in its current state's entry: exactly one lookup and no backtracking. While in_valid is low, every automaton holds its state.
- R4: A table entry is ENT_W = 2^SLICE_W*PTR_W + KW_N bits wide. The pointer for slice value v sits at bits [v*PTR_W +: PTR_W], and the partial-match vector takes the top KW_N bits, where bit j stands for keyword j. A write of wr_data to the entry wr_addr of automaton wr_slice takes effect when wr_en is high and the stream is idle.
- R5: One cycle after a byte with in_valid high, out_valid is 1 and out_match is the AND of the partial-match vectors of the states all automata entered on that byte. Whenever out_valid is 0, out_match is 0.
- R6: A byte with in_sop high is looked up from state 0 in every automaton, whatever the earlier stream was. A keyword therefore never matches across a packet boundary.
- R7: A write is ignored, and the table is left unchanged, while a packet is open (from its in_sop byte up to and including its in_eop byte) or while in_valid is high.
- R8: out_any is 1 when any bit of out_match has been set since the latest in_sop byte, that byte included. It is cleared by the next in_sop byte that matches nothing. out_eop is in_eop registered with the same latency as out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_sop | input | 1 | The byte is the first of a packet |
| in_eop | input | 1 | The byte is the last of a packet |
| in_byte | input | 8 | Stream byte |
| wr_en | input | 1 | Table write strobe |
| wr_slice | input | SEL_W | Index of the automaton to write |
| wr_addr | input | PTR_W | State entry to write |
| wr_data | input | ENT_W | Entry contents: pointers, then the vector on top |
| out_valid | output | 1 | out_match holds the result of the previous byte |
| out_match | output | KW_N | One bit per keyword that ends at that byte |
| out_eop | output | 1 | The previous byte closed its packet |
| out_any | output | 1 | Sticky match flag for the current packet |

## Verification
Assertions check on every cycle four things: out_match is zero unless out_valid is high, out_eop never appears without out_valid, out_any stays set until a start-of-packet byte, and an automaton holds its state on cycles without a byte. Whether the reported vector is the right one can only be shown by the bench. The bench loads automata that track a suffix of the slice history and compares each output against keyword endings found directly in the byte history. Its scenarios also cover matches on the first byte of a packet, a keyword split across two packets, gaps inside packets, and table writes attempted while a packet is open.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    localparam int BYTE_W = 8;

    // number of automata needed to cover one byte
    function automatic int slice_count(input int slice_w);
        return BYTE_W / slice_w;
    endfunction

    // width of an automaton-select field, at least one bit
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/bsm_slice.sv
module bsm_slice #(
    parameter int SLICE_W = 1,
    parameter int PTR_W   = 9,
    parameter int STATE_N = 384,
    parameter int KW_N    = 16,
    localparam int NPTR   = 1 << SLICE_W,
    localparam int ENT_W  = NPTR * PTR_W + KW_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               restart_i,
    input  logic [SLICE_W-1:0] sym_i,
    input  logic               we_i,
    input  logic [PTR_W-1:0]   waddr_i,
    input  logic [ENT_W-1:0]   wdata_i,
    output logic [KW_N-1:0]    vec_o
);
    localparam logic [PTR_W:0] LIMIT = (PTR_W + 1)'(STATE_N);

    typedef struct packed {
        logic [PTR_W-1:0] state;
    } slice_st_t;

    slice_st_t        st_q, st_d;
    logic [ENT_W-1:0] tbl [STATE_N];
    logic [PTR_W-1:0] cur, nxt, nidx;
    logic [ENT_W-1:0] ent;

    always_comb begin
        cur   = restart_i ? '0 : st_q.state;
        ent   = tbl[cur];
        nxt   = ent[int'(sym_i) * PTR_W +: PTR_W];
        nidx  = ({1'b0, nxt} < LIMIT) ? nxt : '0;
        vec_o = tbl[nidx][ENT_W-1 -: KW_N];
        st_d  = st_q;
        if (step_i) st_d.state = nidx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (we_i) tbl[waddr_i] <= wdata_i;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(st_q.state)); // R3
endmodule

// File: rtl/bitsplit_matcher.sv
module bitsplit_matcher #(
    parameter int SLICE_W = 1,
    parameter int KW_N    = 16,
    parameter int PTR_W   = 9,
    parameter int STATE_N = 384,
    localparam int SLICES = bsm_pkg::slice_count(SLICE_W),
    localparam int NPTR   = 1 << SLICE_W,
    localparam int ENT_W  = NPTR * PTR_W + KW_N,
    localparam int SEL_W  = bsm_pkg::sel_width(SLICES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [7:0]         in_byte,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_slice,
    input  logic [PTR_W-1:0]   wr_addr,
    input  logic [ENT_W-1:0]   wr_data,
    output logic               out_valid,
    output logic [KW_N-1:0]    out_match,
    output logic               out_eop,
    output logic               out_any
);
    localparam logic [PTR_W:0] LIMIT = (PTR_W + 1)'(STATE_N);

    typedef struct packed {
        logic            active;
        logic            valid;
        logic            eop;
        logic            any;
        logic [KW_N-1:0] match;
    } top_st_t;

    top_st_t         st_q, st_d;
    logic [KW_N-1:0] vec [SLICES];
    logic [KW_N-1:0] andv;
    logic            wr_ok;

    assign wr_ok = wr_en && !st_q.active && !in_valid && ({1'b0, wr_addr} < LIMIT);

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        bsm_slice #(
            .SLICE_W(SLICE_W), .PTR_W(PTR_W), .STATE_N(STATE_N), .KW_N(KW_N)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_i   (in_valid),
            .restart_i(in_sop),
            .sym_i    (in_byte[i*SLICE_W +: SLICE_W]),
            .we_i     (wr_ok && (wr_slice == SEL_W'(i))),
            .waddr_i  (wr_addr),
            .wdata_i  (wr_data),
            .vec_o    (vec[i])
        );
    end

    always_comb begin
        andv = '1;
        for (int i = 0; i < SLICES; i++) andv &= vec[i];

        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.eop   = in_valid && in_eop;
        st_d.match = in_valid ? andv : '0;
        if (in_valid) begin
            st_d.any = (in_sop ? 1'b0 : st_q.any) | (|andv);
            if (in_eop)      st_d.active = 1'b0;
            else if (in_sop) st_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_match = st_q.match;
    assign out_eop   = st_q.eop;
    assign out_any   = st_q.any;

    AST_MATCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_match == '0)); // R5
    AST_EOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_valid); // R8
    AST_ANY_SEES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (|out_match)) |-> out_any); // R8
    AST_ANY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_any && !(in_valid && in_sop)) |=> out_any); // R8
endmodule

// File: tb/tb_bitsplit_matcher.sv
module tb_bitsplit_matcher;
    localparam int SW = 1, KN = 16, PW = 9, SN = 384;
    localparam int NSL = 8, EW = 2 * PW + KN;

    logic          clk = 0, rst_n = 0;
    logic          in_valid = 0, in_sop = 0, in_eop = 0;
    logic [7:0]    in_byte = 0;
    logic          wr_en = 0;
    logic [2:0]    wr_slice = 0;
    logic [PW-1:0] wr_addr = 0;
    logic [EW-1:0] wr_data = 0;
    logic          out_valid, out_eop, out_any;
    logic [KN-1:0] out_match;

    bitsplit_matcher #(.SLICE_W(SW), .KW_N(KN), .PTR_W(PW), .STATE_N(SN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_byte(in_byte), .wr_en(wr_en), .wr_slice(wr_slice),
        .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(out_valid),
        .out_match(out_match), .out_eop(out_eop), .out_any(out_any));

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;
    int kw_len [KN];
    logic [7:0] kw [KN][4];
    logic [7:0] hist [256];
    int hlen = 0;
    bit m_any = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] alpha [8];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void set_kw(input int j, input string s);
        kw_len[j] = s.len();
        for (int p = 0; p < s.len(); p++) kw[j][p] = s[p];
    endfunction

    // vector of a suffix-tracking state: bit p of s is the slice bit p bytes back
    function automatic logic [KN-1:0] slice_vec(input int sl, input int s);
        logic [KN-1:0] v = '0;
        for (int j = 0; j < KN; j++) begin
            bit ok = 1;
            for (int p = 0; p < kw_len[j]; p++)
                if (((s >> p) & 1) != ((kw[j][kw_len[j]-1-p] >> sl) & 1)) ok = 0;
            v[j] = ok;
        end
        return v;
    endfunction

    function automatic logic [KN-1:0] model_match();
        logic [KN-1:0] v = '0;
        for (int j = 0; j < KN; j++) begin
            bit ok = (hlen >= kw_len[j]);
            for (int p = 0; p < kw_len[j] && ok; p++)
                if (hist[hlen - kw_len[j] + p] != kw[j][p]) ok = 0;
            v[j] = ok;
        end
        return v;
    endfunction

    task automatic write_entry(input int sl, input int a, input logic [EW-1:0] d);
        wr_en = 1; wr_slice = 3'(sl); wr_addr = PW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic send(input logic [7:0] b, input bit sop, input bit eop, input string tag);
        logic [KN-1:0] exp;
        in_valid = 1; in_sop = sop; in_eop = eop; in_byte = b;
        if (sop) begin hlen = 0; m_any = 0; end
        hist[hlen] = b; hlen++;
        exp = model_match();
        m_any = m_any | (|exp);
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
        chk(out_valid == 1, tag, "out_valid", 32'(out_valid), 1);
        chk(out_match == exp, sop ? "R6" : tag, "out_match", 32'(out_match), 32'(exp));
        chk(out_eop == eop, "R8", "out_eop", 32'(out_eop), 32'(eop));
        if (eop) chk(out_any == m_any, "R8", "out_any", 32'(out_any), 32'(m_any));
    endtask

    task automatic gap();
        @(negedge clk);
        chk(out_valid == 0 && out_match == 0, "R5", "idle output", 32'(out_match), 0);
    endtask

    function automatic logic [7:0] rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return alpha[lfsr[2:0]];
    endfunction

    task automatic rand_packet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            send(rnd(), i == 0, i == n - 1, tag);
            if (lfsr[5:3] == 0 && i != n - 1) gap();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        alpha = '{"h", "e", "r", "i", "m", "s", "x", "a"};
        set_kw(0, "he");   set_kw(1, "her");  set_kw(2, "him");  set_kw(3, "his");
        set_kw(4, "she");  set_kw(5, "is");   set_kw(6, "e");    set_kw(7, "ss");
        set_kw(8, "hers"); set_kw(9, "mi");   set_kw(10, "x");   set_kw(11, "rh");
        set_kw(12, "sh");  set_kw(13, "ie");  set_kw(14, "ax");  set_kw(15, "ms");

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 0, "R1", "out_valid", 32'(out_valid), 0);
        chk(out_match == 0, "R1", "out_match", 32'(out_match), 0);
        chk(out_eop == 0, "R1", "out_eop", 32'(out_eop), 0);
        chk(out_any == 0, "R1", "out_any", 32'(out_any), 0);

        // R4 program eight single-bit automata (R2 slice i = byte bit i)
        for (int sl = 0; sl < NSL; sl++)
            for (int s = 0; s < 256; s++)
                write_entry(sl, s, {slice_vec(sl, s), PW'(((s << 1) | 1) & 255), PW'((s << 1) & 255)});

        // R3 directed packets
        send("h", 1, 0, "R3"); send("e", 0, 0, "R3"); send("r", 0, 0, "R3");
        send("s", 0, 1, "R3");
        send("x", 1, 1, "R6");
        // R6 keyword split over two packets must not match
        send("s", 1, 0, "R6"); send("h", 0, 1, "R6");
        send("e", 1, 0, "R6");
        chk(out_match[0] == 0 && out_match[4] == 0, "R6", "no cross-packet he/she",
            32'(out_match), 32'(model_match()));
        send("a", 0, 1, "R6");
        // R3 gaps inside a packet hold state
        send("h", 1, 0, "R3"); gap(); gap(); send("i", 0, 0, "R3"); gap();
        send("s", 0, 1, "R3");
        // R8 packet with no match leaves out_any low
        send("a", 1, 0, "R8"); send("a", 0, 1, "R8");

        // R7 writes during an open packet must be ignored
        send("m", 1, 0, "R7");
        for (int sl = 0; sl < NSL; sl++)
            for (int s = 0; s < 256; s++) write_entry(sl, s, '0);
        send("i", 0, 0, "R7"); send("s", 0, 0, "R7"); send("s", 0, 1, "R7");
        send("h", 1, 0, "R7"); send("e", 0, 0, "R7"); send("r", 0, 0, "R7");
        send("s", 0, 1, "R7");

        // R5 random traffic sweep
        for (int k = 0; k < 60; k++) rand_packet(1 + (k % 23), "R5");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule